// File: doc/BRIEF.md
# Vectored Interrupt Entry and Return Sequencer

This block is the hardwired controller that a processor runs between instructions. Each time the execute phase of an instruction finishes, the core pulses `instr_done` and waits for `fetch_go`. The sequencer then spends one cycle in a separate check phase and decides how to continue. It can resume fetch straight away, or it can enter an interrupt routine. It can also carry out a return from a routine when the finished instruction was a return instruction.

Three causes lead to an entry: a software interrupt instruction, an unmasked external request, and single-step trace mode. The entry sequence works as follows:

- For an external request, the sequencer first obtains a vector number from the requesting controller through a request/acknowledge handshake. The other two causes supply their vector directly.
- It pushes the program counter and the status word onto a byte-wide stack through memory write cycles.
- It reads the routine's 16-bit start address from a vector table in memory.
- When the sequence finishes, it hands the new PC, PSW and SP values back to the core with a one-cycle `commit` strobe, in the same cycle as `fetch_go`.

The return sequence pops the three saved bytes in the opposite order. A routine that sets the enable bit again may itself be interrupted, because every entry works only from the PC, PSW and SP values presented at that instruction boundary.

Top module: `irq_svc_seq`

## Requirements
- R1: When no cause is present at an instruction boundary, `fetch_go` is high for one cycle exactly two clock edges after the edge that sampled `instr_done`. In that case `commit` stays low and no memory or vector cycle is issued.
- R2: An external entry takes the lowest-numbered source among `irq_lines & irq_mask`. The sequencer presents that number on `vec_src` while `vec_req` is high, and it uses the `vec_num` returned with `vec_ack` as the vector.
- R3: A source whose `irq_mask` bit is 0 is never taken. When PSW bit 7 (global enable) is 0, no external source is taken.
- R4: An entry writes three bytes, each to the stack pointer after it has been decremented: PC[15:8] at SP-1, then PC[7:0] at SP-2, then the PSW at SP-3. The final `sp_out` is SP-3.
- R5: After the pushes, the entry reads the vector table, low byte from `VTAB_BASE + 2*vector` and then high byte from the next address. `pc_out` is {high, low}.
- R6: On entry, `psw_out` equals the saved PSW with bit 7 (enable) and bit 6 (trace) cleared. The pushed PSW byte is the unmodified value.
- R7: With `swi_req`, an entry is made even when the enable bit is 0. It uses `swi_vec` as the vector, issues no vector handshake, and takes precedence over pending external requests.
- R8: With PSW bit 6 set and no other cause, an entry uses vector `TRACE_VEC`. An unmasked, enabled external request present at the same boundary is serviced instead of the trace trap.
- R9: With `reti_req`, the sequencer reads PSW from SP, PC[7:0] from SP+1 and PC[15:8] from SP+2. It commits those values with `sp_out` = SP+3.
- R10: A memory or vector request, once raised, stays high with stable address, direction and source until it is acknowledged. Memory and vector requests are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_done | input | 1 | Execute phase of an instruction finished |
| reti_req | input | 1 | Finished instruction was a return from interrupt |
| swi_req | input | 1 | Finished instruction was a software interrupt |
| swi_vec | input | 8 | Vector number of the software interrupt |
| irq_lines | input | N_SRC | External request levels, one per source |
| irq_mask | input | N_SRC | Per-source enable, 1 = allowed |
| pc_in | input | 16 | Program counter at the boundary |
| psw_in | input | 8 | Status word at the boundary (bit 7 enable, bit 6 trace) |
| sp_in | input | 16 | Stack pointer at the boundary |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Memory cycle complete |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| vec_req | output | 1 | Vector number acquisition request |
| vec_src | output | SRC_W | Source addressed by the acquisition |
| vec_ack | input | 1 | Vector number valid |
| vec_num | input | 8 | Acquired vector number |
| fetch_go | output | 1 | Resume instruction fetch |
| commit | output | 1 | Load `pc_out`, `psw_out`, `sp_out` into the core |
| pc_out | output | 16 | New program counter |
| psw_out | output | 8 | New status word |
| sp_out | output | 16 | New stack pointer |

## Verification
Two functions can coincide at one boundary: the single-step trap and an external request, or a software interrupt and an external request. The bench provokes both cases by raising the trace bit, or by issuing the software interrupt instruction, while unmasked requests are pending. The winner is judged by its observable effects: the vector handshake with the expected source, the table address the vector selects, and the committed PC. The bench's reference model derives the full list of bus transactions for every case. It compares each memory cycle, in order, against that list when the cycle is acknowledged.

// File: rtl/irq_svc_pkg.sv
package irq_svc_pkg;

    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int PSW_EN_BIT = 7;
    localparam int PSW_TR_BIT = 6;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CHECK,
        S_VEC,
        S_PUSH_PCH,
        S_PUSH_PCL,
        S_PUSH_PSW,
        S_TBL_LO,
        S_TBL_HI,
        S_POP_PSW,
        S_POP_PCL,
        S_POP_PCH,
        S_DONE
    } seq_state_t;

    typedef struct packed {
        logic                req;
        logic                we;
        logic [ADDR_W-1:0]   addr;
        logic [BYTE_W-1:0]   wdata;
    } mem_cmd_t;

    function automatic logic [BYTE_W-1:0] strip_ctl(input logic [BYTE_W-1:0] psw);
        logic [BYTE_W-1:0] r;
        r = psw;
        r[PSW_EN_BIT] = 1'b0;
        r[PSW_TR_BIT] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/irq_prio.sv
module irq_prio #(
    parameter int N_SRC = 4,
    parameter int SRC_W = 2
) (
    input  logic [N_SRC-1:0] req,
    output logic             any,
    output logic [SRC_W-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req[i]) idx = SRC_W'(i);
        end
    end
endmodule

// File: rtl/irq_bus_mux.sv
module irq_bus_mux
    import irq_svc_pkg::*;
#(
    parameter logic [ADDR_W-1:0] VTAB_BASE = 16'h0100
) (
    input  seq_state_t        st,
    input  logic [ADDR_W-1:0] sp,
    input  logic [ADDR_W-1:0] pc,
    input  logic [BYTE_W-1:0] psw,
    input  logic [BYTE_W-1:0] vec,
    output mem_cmd_t          cmd
);
    logic [ADDR_W-1:0] tbl_addr;

    always_comb begin
        tbl_addr = VTAB_BASE + (ADDR_W'(vec) << 1);
        cmd = '0;
        case (st)
            S_PUSH_PCH: cmd = '{req: 1'b1, we: 1'b1, addr: sp - 16'd1, wdata: pc[15:8]};
            S_PUSH_PCL: cmd = '{req: 1'b1, we: 1'b1, addr: sp - 16'd1, wdata: pc[7:0]};
            S_PUSH_PSW: cmd = '{req: 1'b1, we: 1'b1, addr: sp - 16'd1, wdata: psw};
            S_TBL_LO:   cmd = '{req: 1'b1, we: 1'b0, addr: tbl_addr, wdata: '0};
            S_TBL_HI:   cmd = '{req: 1'b1, we: 1'b0, addr: tbl_addr + 16'd1, wdata: '0};
            S_POP_PSW,
            S_POP_PCL,
            S_POP_PCH:  cmd = '{req: 1'b1, we: 1'b0, addr: sp, wdata: '0};
            default:    cmd = '0;
        endcase
    end
endmodule

// File: rtl/irq_svc_seq.sv
module irq_svc_seq
    import irq_svc_pkg::*;
#(
    parameter int                N_SRC     = 4,
    parameter logic [15:0]       VTAB_BASE = 16'h0100,
    parameter logic [7:0]        TRACE_VEC = 8'h01,
    localparam int               SRC_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_done,
    input  logic              reti_req,
    input  logic              swi_req,
    input  logic [7:0]        swi_vec,
    input  logic [N_SRC-1:0]  irq_lines,
    input  logic [N_SRC-1:0]  irq_mask,
    input  logic [15:0]       pc_in,
    input  logic [7:0]        psw_in,
    input  logic [15:0]       sp_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic [15:0]       mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    output logic              vec_req,
    output logic [SRC_W-1:0]  vec_src,
    input  logic              vec_ack,
    input  logic [7:0]        vec_num,
    output logic              fetch_go,
    output logic              commit,
    output logic [15:0]       pc_out,
    output logic [7:0]        psw_out,
    output logic [15:0]       sp_out
);
    seq_state_t         st;
    logic [ADDR_W-1:0]  pc_w, sp_w;
    logic [BYTE_W-1:0]  psw_w, vec_w, swv_w;
    logic [SRC_W-1:0]   src_w;
    logic               taken, ret_f, swi_f;
    logic               ext_any;
    logic [SRC_W-1:0]   ext_idx;
    mem_cmd_t           cmd;

    irq_prio #(.N_SRC(N_SRC), .SRC_W(SRC_W)) prio_i (
        .req (irq_lines & irq_mask),
        .any (ext_any),
        .idx (ext_idx)
    );

    irq_bus_mux #(.VTAB_BASE(VTAB_BASE)) mux_i (
        .st  (st),
        .sp  (sp_w),
        .pc  (pc_w),
        .psw (psw_w),
        .vec (vec_w),
        .cmd (cmd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= S_IDLE;
            pc_w  <= '0;
            sp_w  <= '0;
            psw_w <= '0;
            vec_w <= '0;
            swv_w <= '0;
            src_w <= '0;
            taken <= 1'b0;
            ret_f <= 1'b0;
            swi_f <= 1'b0;
        end else begin
            case (st)
                S_IDLE: if (instr_done) begin
                    pc_w  <= pc_in;
                    psw_w <= psw_in;
                    sp_w  <= sp_in;
                    ret_f <= reti_req;
                    swi_f <= swi_req;
                    swv_w <= swi_vec;
                    taken <= 1'b0;
                    st    <= S_CHECK;
                end
                S_CHECK: begin
                    if (ret_f) begin
                        taken <= 1'b1;
                        st    <= S_POP_PSW;
                    end else if (swi_f) begin
                        taken <= 1'b1;
                        vec_w <= swv_w;
                        st    <= S_PUSH_PCH;
                    end else if (psw_w[PSW_EN_BIT] && ext_any) begin
                        taken <= 1'b1;
                        src_w <= ext_idx;
                        st    <= S_VEC;
                    end else if (psw_w[PSW_TR_BIT]) begin
                        taken <= 1'b1;
                        vec_w <= TRACE_VEC;
                        st    <= S_PUSH_PCH;
                    end else begin
                        st    <= S_DONE;
                    end
                end
                S_VEC: if (vec_ack) begin
                    vec_w <= vec_num;
                    st    <= S_PUSH_PCH;
                end
                S_PUSH_PCH: if (mem_ack) begin
                    sp_w <= sp_w - 16'd1;
                    st   <= S_PUSH_PCL;
                end
                S_PUSH_PCL: if (mem_ack) begin
                    sp_w <= sp_w - 16'd1;
                    st   <= S_PUSH_PSW;
                end
                S_PUSH_PSW: if (mem_ack) begin
                    sp_w  <= sp_w - 16'd1;
                    psw_w <= strip_ctl(psw_w);
                    st    <= S_TBL_LO;
                end
                S_TBL_LO: if (mem_ack) begin
                    pc_w[7:0] <= mem_rdata;
                    st        <= S_TBL_HI;
                end
                S_TBL_HI: if (mem_ack) begin
                    pc_w[15:8] <= mem_rdata;
                    st         <= S_DONE;
                end
                S_POP_PSW: if (mem_ack) begin
                    psw_w <= mem_rdata;
                    sp_w  <= sp_w + 16'd1;
                    st    <= S_POP_PCL;
                end
                S_POP_PCL: if (mem_ack) begin
                    pc_w[7:0] <= mem_rdata;
                    sp_w      <= sp_w + 16'd1;
                    st        <= S_POP_PCH;
                end
                S_POP_PCH: if (mem_ack) begin
                    pc_w[15:8] <= mem_rdata;
                    sp_w       <= sp_w + 16'd1;
                    st         <= S_DONE;
                end
                S_DONE:  st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    assign mem_req   = cmd.req;
    assign mem_we    = cmd.we;
    assign mem_addr  = cmd.addr;
    assign mem_wdata = cmd.wdata;
    assign vec_req   = (st == S_VEC);
    assign vec_src   = src_w;
    assign fetch_go  = (st == S_DONE);
    assign commit    = (st == S_DONE) && taken;
    assign pc_out    = pc_w;
    assign psw_out   = psw_w;
    assign sp_out    = sp_w;

endmodule

// File: rtl/irq_svc_seq_chk.sv
module irq_svc_seq_chk #(
    parameter int SRC_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             mem_req,
    input logic             mem_we,
    input logic [15:0]      mem_addr,
    input logic             mem_ack,
    input logic             vec_req,
    input logic [SRC_W-1:0] vec_src,
    input logic             vec_ack,
    input logic             fetch_go,
    input logic             commit
);
    p_mem_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)))
        else $error("memory request dropped or changed before ack");

    p_vec_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (vec_req && !vec_ack) |=> (vec_req && $stable(vec_src)))
        else $error("vector request dropped or changed before ack");

    p_bus_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && vec_req))
        else $error("memory and vector requests overlap");

    p_commit_fetch_r1: assert property (@(posedge clk) disable iff (rst)
        commit |-> fetch_go)
        else $error("commit without fetch_go");

    p_quiet_after_go_r1: assert property (@(posedge clk) disable iff (rst)
        fetch_go |=> (!mem_req && !vec_req && !fetch_go))
        else $error("activity right after fetch_go");
endmodule

bind irq_svc_seq irq_svc_seq_chk #(.SRC_W(SRC_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .vec_req  (vec_req),
    .vec_src  (vec_src),
    .vec_ack  (vec_ack),
    .fetch_go (fetch_go),
    .commit   (commit)
);

// File: tb/irq_svc_seq_tb_top.sv
`timescale 1ns/1ps
module irq_svc_seq_tb_top;
    localparam int          NS    = 4;
    localparam int          SW    = 2;
    localparam logic [15:0] VTAB  = 16'h0100;
    localparam logic [7:0]  TRV   = 8'h01;

    typedef struct packed {
        logic        we;
        logic [15:0] a;
        logic [7:0]  d;
    } xact_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic instr_done = 0, reti_req = 0, swi_req = 0;
    logic [7:0] swi_vec = '0;
    logic [NS-1:0] irq_lines = '0, irq_mask = '0;
    logic [15:0] pc_in = '0, sp_in = '0;
    logic [7:0] psw_in = '0;
    logic mem_req, mem_we, mem_ack, vec_req, vec_ack, fetch_go, commit;
    logic [15:0] mem_addr, pc_out, sp_out;
    logic [7:0] mem_wdata, mem_rdata, vec_num, psw_out;
    logic [SW-1:0] vec_src;

    always #2 clk = ~clk;

    irq_svc_seq #(.N_SRC(NS), .VTAB_BASE(VTAB), .TRACE_VEC(TRV)) dut_i (
        .clk(clk), .rst(rst), .instr_done(instr_done), .reti_req(reti_req),
        .swi_req(swi_req), .swi_vec(swi_vec), .irq_lines(irq_lines), .irq_mask(irq_mask),
        .pc_in(pc_in), .psw_in(psw_in), .sp_in(sp_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .vec_req(vec_req), .vec_src(vec_src), .vec_ack(vec_ack), .vec_num(vec_num),
        .fetch_go(fetch_go), .commit(commit), .pc_out(pc_out), .psw_out(psw_out), .sp_out(sp_out)
    );

    int n_chk = 0, n_fail = 0;
    logic [7:0] mem [int];
    xact_t exp_q [$];
    int exp_src = -1;
    int mem_wait = 0;
    string cur_tag = "R0";

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] rd(input logic [15:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return 8'h00;
    endfunction

    // memory responder with optional wait states
    initial begin
        int wcnt;
        logic [15:0] held;
        wcnt = 0; held = '0;
        mem_ack = 0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 0; wcnt = 0;
            end else if (mem_req) begin
                if (wcnt > 0) chk(mem_addr == held, "R10", "address held while waiting", mem_addr, held);
                held = mem_addr;
                if (wcnt < mem_wait) wcnt++;
                else begin
                    if (exp_q.size() == 0) begin
                        chk(0, cur_tag, "unexpected memory cycle", mem_addr, 0);
                    end else begin
                        xact_t e;
                        e = exp_q.pop_front();
                        chk(mem_we == e.we, cur_tag, "cycle direction", mem_we, e.we);
                        chk(mem_addr == e.a, cur_tag, "cycle address", mem_addr, e.a);
                        if (e.we) chk(mem_wdata == e.d, cur_tag, "write data", mem_wdata, e.d);
                    end
                    if (mem_we) mem[int'(mem_addr)] = mem_wdata;
                    else mem_rdata = rd(mem_addr);
                    mem_ack = 1;
                end
            end
        end
    end

    // vector acquisition responder: source i answers 0x20 + i
    initial begin
        vec_ack = 0; vec_num = '0;
        forever begin
            @(negedge clk);
            if (vec_ack) vec_ack = 0;
            else if (vec_req) begin
                chk(exp_src >= 0, "R2", "vector cycle expected", vec_src, 32'(exp_src));
                chk(int'(vec_src) == exp_src, "R2", "vector source", vec_src, 32'(exp_src));
                vec_num = 8'h20 + 8'(vec_src);
                vec_ack = 1;
                exp_src = -1;
            end
        end
    end

    // reference model: derive bus cycles and outcome for one boundary
    task automatic run_case(input string tag, input logic [15:0] pc, input logic [7:0] psw,
                            input logic [15:0] sp, input logic [NS-1:0] irq, input logic [NS-1:0] msk,
                            input logic swi, input logic [7:0] sv, input logic rt);
        int kind;  // 0 none, 1 entry, 2 return
        logic [7:0] v;
        logic [15:0] tb, pc_e, sp_e;
        logic [7:0] psw_e;
        int cyc;
        kind = 0; v = '0; pc_e = '0; sp_e = '0; psw_e = '0;
        exp_src = -1;
        cur_tag = tag;
        if (rt) kind = 2;
        else if (swi) begin kind = 1; v = sv; end
        else if (psw[7] && |(irq & msk)) begin
            kind = 1;
            for (int i = NS - 1; i >= 0; i--) if (irq[i] && msk[i]) exp_src = i;
            v = 8'h20 + 8'(exp_src);
        end else if (psw[6]) begin kind = 1; v = TRV; end
        if (kind == 1) begin
            tb = VTAB + 16'(v) * 16'd2;
            exp_q.push_back('{1'b1, sp - 16'd1, pc[15:8]});
            exp_q.push_back('{1'b1, sp - 16'd2, pc[7:0]});
            exp_q.push_back('{1'b1, sp - 16'd3, psw});
            exp_q.push_back('{1'b0, tb, 8'h00});
            exp_q.push_back('{1'b0, tb + 16'd1, 8'h00});
            pc_e = {rd(tb + 16'd1), rd(tb)};
            psw_e = psw & 8'h3F;
            sp_e = sp - 16'd3;
        end else if (kind == 2) begin
            exp_q.push_back('{1'b0, sp, 8'h00});
            exp_q.push_back('{1'b0, sp + 16'd1, 8'h00});
            exp_q.push_back('{1'b0, sp + 16'd2, 8'h00});
            psw_e = rd(sp);
            pc_e = {rd(sp + 16'd2), rd(sp + 16'd1)};
            sp_e = sp + 16'd3;
        end
        @(negedge clk);
        pc_in = pc; psw_in = psw; sp_in = sp; irq_lines = irq; irq_mask = msk;
        swi_req = swi; swi_vec = sv; reti_req = rt; instr_done = 1;
        @(negedge clk);
        instr_done = 0; swi_req = 0; reti_req = 0;
        cyc = 1;
        while (!fetch_go && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        chk(fetch_go == 1'b1, tag, "fetch_go reached", fetch_go, 1);
        if (kind == 0) begin
            chk(cyc == 2, tag, "fetch_go timing", cyc, 2);
            chk(commit == 1'b0, tag, "no commit", commit, 0);
        end else begin
            chk(commit == 1'b1, tag, "commit", commit, 1);
            chk(pc_out == pc_e, tag, "pc_out", pc_out, pc_e);
            chk(psw_out == psw_e, tag, "psw_out", psw_out, psw_e);
            chk(sp_out == sp_e, tag, "sp_out", sp_out, sp_e);
        end
        chk(exp_q.size() == 0, tag, "pending memory cycles", exp_q.size(), 0);
        chk(exp_src == -1, tag, "pending vector cycle", 32'(exp_src), 32'hFFFFFFFF);
        exp_q.delete();
        exp_src = -1;
        @(negedge clk);
        irq_lines = '0;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "R0", "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int v = 0; v < 64; v++) begin
            mem[int'(VTAB) + 2*v]     = 8'(v * 5 + 3);
            mem[int'(VTAB) + 2*v + 1] = 8'h80 + 8'(v);
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(fetch_go == 0 && commit == 0, "R1", "reset outputs quiet", {fetch_go, commit}, 0);
        chk(mem_req == 0 && vec_req == 0, "R10", "reset requests low", {mem_req, vec_req}, 0);

        run_case("R1", 16'h1234, 8'h80, 16'h2000, 4'b0000, 4'b1111, 0, 8'h00, 0);
        run_case("R3", 16'h1234, 8'h80, 16'h2000, 4'b0010, 4'b1101, 0, 8'h00, 0);
        run_case("R3", 16'h1234, 8'h00, 16'h2000, 4'b1111, 4'b1111, 0, 8'h00, 0);
        // external entry; stack left for the return case below (R4 R5 R6)
        run_case("R4", 16'hA5C3, 8'h85, 16'h2000, 4'b1010, 4'b1111, 0, 8'h00, 0);
        run_case("R9", 16'h0000, 8'h00, 16'h1FFD, 4'b0000, 4'b0000, 0, 8'h00, 1);
        mem_wait = 2;
        run_case("R10", 16'h4321, 8'hC0, 16'h3000, 4'b1000, 4'b1111, 0, 8'h00, 0);
        mem_wait = 0;
        run_case("R7", 16'h0F0F, 8'h00, 16'h2000, 4'b0001, 4'b1111, 1, 8'h07, 0);
        run_case("R7", 16'h0F10, 8'hC2, 16'h2000, 4'b0001, 4'b1111, 1, 8'h09, 0);
        run_case("R8", 16'h5555, 8'h40, 16'h2000, 4'b0000, 4'b1111, 0, 8'h00, 0);
        run_case("R8", 16'h5556, 8'hC0, 16'h2000, 4'b0100, 4'b0111, 0, 8'h00, 0);
        run_case("R6", 16'h7777, 8'hFF, 16'h2400, 4'b0001, 4'b0001, 0, 8'h00, 0);
        // nested entry from inside a routine that set the enable bit again
        run_case("R2", 16'h8123, 8'h80, 16'h1FFD, 4'b1001, 4'b1110, 0, 8'h00, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule